// File: doc/BRIEF.md
# Pipelined SPI ADC scan sequencer

This block is an SPI controller for a multichannel successive-approximation converter whose answers lag its commands by two frames. A host presents a channel-enable mask, a range choice and a one-cycle start pulse. The block then sends one 16-bit command per enabled channel, lowest channel first, and follows them with two flush frames. The converter returns the result for a command two frames after that command, so the receive stream runs two frames behind the transmit stream. Each returned word is checked against the channel that was asked for and unpacked into a sample. The sample is presented on a result port with a valid strobe and a tag-mismatch flag.

A single-channel mode takes three frames. The command is sent, then sent again while the converter works, and the result is captured in a third, empty frame. The serial clock comes from a plain divider of the system clock. The link runs with the clock idle low, data launched while the clock is low and sampled on its rising edge, most significant bit first.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, cs_n=1, sclk=0, mosi=0, busy=0, res_valid=0 and done=0.
- R2: Every frame keeps cs_n low for exactly 16 sclk rising edges. sclk is low whenever cs_n is high. mosi changes only while sclk is low, and the most significant bit goes out first.
- R3: Between two consecutive frames, cs_n stays high for at least one full sclk period (2*DIV clock cycles).
- R4: A command word has bits 15:13 = 0, bit 12 = 1 (manual select), bit 11 = 1 (program enable), bits 10:7 = channel, bit 6 = range_dbl latched at start, and bits 5:0 = 0.
- R5: A scan with K bits set in ch_en sends exactly K+2 frames. The first K carry commands for the enabled channels in ascending order. The last two are all-zero flush words.
- R6: Words received in the first two frames of an operation are discarded. The word received in frame N+2 is attributed to the channel commanded in frame N. A scan emits exactly K results, in ascending channel order, each reported on res_ch.
- R7: res_data equals bits 11 down to 12-RES_BITS of the received word.
- R8: res_err is 1 when bits 15:12 of the received word differ from res_ch, and 0 when they match.
- R9: A single read (single_mode=1) sends three frames: the command for single_ch twice, then an all-zero word. It emits one result, taken from the third frame.
- R10: A start pulse while busy=1 has no effect. The running operation's frames and results are unchanged, and no extra operation follows.
- R11: done pulses for exactly one cycle per operation, in the same cycle as the last res_valid. busy is 0 from that cycle on.
- R12: A start with single_mode=0 and ch_en=0 is ignored. No frame is sent, busy stays 0 and done does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| single_mode | input | 1 | 1 selects a single-channel read, 0 a mask scan |
| single_ch | input | 4 | Channel for a single read |
| ch_en | input | NUM_CH | Channel-enable mask for a scan |
| range_dbl | input | 1 | Requests the doubled input range in each command |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select, one low pulse per frame |
| mosi | output | 1 | Serial data to the converter |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse with the last result |
| res_valid | output | 1 | Result strobe |
| res_err | output | 1 | Returned channel tag did not match |
| res_ch | output | 4 | Channel the result belongs to |
| res_data | output | RES_BITS | Extracted sample |

## Verification
Scans are driven with a one-channel mask, with the full 16-channel mask, and with a mask holding only the two end channels. Together these separate a correct two-frame offset from an off-by-one in either direction and expose ordering errors at the mask edges. Random masks with random ranges and sample values catch mixing of channels and range bits. Single reads on channel 0 and channel 15 tell the repeated-command sequence apart from the scan sequence. A converter model that corrupts the tag of one chosen channel shows that the error flag follows exactly that result. A start pulse in the middle of a full scan, and a start with an empty mask, show that both requests are ignored.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int FRAME_BITS     = 16;
    localparam int TAG_BITS       = 4;
    localparam int MAX_CH         = 16;
    localparam int FIELD_BITS     = 12;
    localparam int CMD_MANUAL_BIT = 12;
    localparam int CMD_PROG_BIT   = 11;
    localparam int CMD_CH_LSB     = 7;
    localparam int CMD_RANGE_BIT  = 6;

    typedef logic [FRAME_BITS-1:0] frame_t;
    typedef logic [TAG_BITS-1:0]   chan_t;

    // channel commanded in one frame, if any
    typedef struct packed {
        logic  valid;
        chan_t ch;
    } slot_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SHIFT,
        ENG_GAP
    } eng_state_t;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_RUN
    } seq_state_t;

    function automatic frame_t build_cmd(chan_t ch, logic dbl);
        frame_t w;
        w = '0;
        w[CMD_MANUAL_BIT]              = 1'b1;
        w[CMD_PROG_BIT]                = 1'b1;
        w[CMD_CH_LSB +: TAG_BITS]      = ch;
        w[CMD_RANGE_BIT]               = dbl;
        return w;
    endfunction

    function automatic logic [4:0] count_ones(logic [MAX_CH-1:0] m);
        logic [4:0] n;
        n = '0;
        for (int i = 0; i < MAX_CH; i++) begin
            n = n + {4'd0, m[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/spi_word_engine.sv
module spi_word_engine
    import adc_scan_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   go,
    input  frame_t tx_word,
    input  logic   miso,
    output logic   sclk,
    output logic   cs_n,
    output logic   mosi,
    output logic   ready,
    output logic   frame_done,
    output frame_t rx_word
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int BIT_W = $clog2(FRAME_BITS);

    eng_state_t       st;
    logic [DIV_W-1:0] div_cnt;
    logic             tick;
    logic             phase;
    logic [BIT_W-1:0] bit_cnt;
    logic             gap_cnt;
    frame_t           tx_sr;
    frame_t           rx_sr;

    assign tick  = (div_cnt == DIV_W'(DIV - 1));
    assign ready = (st == ENG_IDLE);
    assign mosi  = cs_n ? 1'b0 : tx_sr[FRAME_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ENG_IDLE;
            div_cnt    <= '0;
            phase      <= 1'b0;
            bit_cnt    <= '0;
            gap_cnt    <= 1'b0;
            tx_sr      <= '0;
            rx_sr      <= '0;
            sclk       <= 1'b0;
            cs_n       <= 1'b1;
            frame_done <= 1'b0;
            rx_word    <= '0;
        end else begin
            frame_done <= 1'b0;
            if (st == ENG_IDLE) begin
                div_cnt <= '0;
            end else begin
                div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
            end
            case (st)
                ENG_IDLE: begin
                    if (go) begin
                        st      <= ENG_SHIFT;
                        tx_sr   <= tx_word;
                        bit_cnt <= '0;
                        phase   <= 1'b0;
                        cs_n    <= 1'b0;
                    end
                end
                ENG_SHIFT: begin
                    if (tick) begin
                        if (!phase) begin
                            sclk  <= 1'b1;
                            rx_sr <= {rx_sr[FRAME_BITS-2:0], miso};
                            phase <= 1'b1;
                        end else begin
                            sclk  <= 1'b0;
                            phase <= 1'b0;
                            if (bit_cnt == BIT_W'(FRAME_BITS - 1)) begin
                                st         <= ENG_GAP;
                                cs_n       <= 1'b1;
                                frame_done <= 1'b1;
                                rx_word    <= rx_sr;
                                gap_cnt    <= 1'b0;
                            end else begin
                                bit_cnt <= bit_cnt + BIT_W'(1);
                                tx_sr   <= {tx_sr[FRAME_BITS-2:0], 1'b0};
                            end
                        end
                    end
                end
                ENG_GAP: begin
                    if (tick) begin
                        if (gap_cnt) begin
                            st <= ENG_IDLE;
                        end else begin
                            gap_cnt <= 1'b1;
                        end
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/chan_picker.sv
module chan_picker
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic [NUM_CH-1:0] mask,
    output logic              found,
    output chan_t             idx
);
    // lowest set bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = chan_t'(i);
            end
        end
    end

endmodule

// File: rtl/word_unpack.sv
module word_unpack
    import adc_scan_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  frame_t              word,
    input  chan_t               expect_ch,
    output logic [RES_BITS-1:0] sample,
    output logic                tag_bad
);
    assign sample  = word[FIELD_BITS-1 -: RES_BITS];
    assign tag_bad = (word[FRAME_BITS-1 -: TAG_BITS] != expect_ch);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int RES_BITS = 12,
    parameter int DIV      = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                single_mode,
    input  logic [3:0]          single_ch,
    input  logic [NUM_CH-1:0]   ch_en,
    input  logic                range_dbl,
    input  logic                miso,
    output logic                sclk,
    output logic                cs_n,
    output logic                mosi,
    output logic                busy,
    output logic                done,
    output logic                res_valid,
    output logic                res_err,
    output logic [3:0]          res_ch,
    output logic [RES_BITS-1:0] res_data
);
    localparam int CNT_W = $clog2(NUM_CH + 3);

    seq_state_t          st;
    logic [NUM_CH-1:0]   pend;
    logic                rng_q;
    logic                one_q;
    chan_t               one_ch;
    logic [CNT_W-1:0]    total;
    logic [CNT_W-1:0]    launched;
    logic [CNT_W-1:0]    finished;
    slot_t               cur;
    slot_t               hist0;
    slot_t               hist1;

    logic                pk_found;
    chan_t               pk_idx;
    slot_t               cmd_slot;
    frame_t              tx_word;
    frame_t              rx_word;
    logic                go;
    logic                eng_ready;
    logic                frame_done;
    logic                start_ok;
    logic [MAX_CH-1:0]   en_wide;
    logic [RES_BITS-1:0] up_sample;
    logic                up_bad;

    chan_picker #(.NUM_CH(NUM_CH)) picker_i (
        .mask  (pend),
        .found (pk_found),
        .idx   (pk_idx)
    );

    spi_word_engine #(.DIV(DIV)) engine_i (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .tx_word    (tx_word),
        .miso       (miso),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .mosi       (mosi),
        .ready      (eng_ready),
        .frame_done (frame_done),
        .rx_word    (rx_word)
    );

    word_unpack #(.RES_BITS(RES_BITS)) unpack_i (
        .word      (rx_word),
        .expect_ch (hist1.ch),
        .sample    (up_sample),
        .tag_bad   (up_bad)
    );

    assign en_wide  = MAX_CH'(ch_en);
    assign busy     = (st == SEQ_RUN);
    assign start_ok = (st == SEQ_IDLE) && start && (single_mode || (ch_en != '0));
    assign go       = (st == SEQ_RUN) && eng_ready && (launched < total);

    always_comb begin
        if (one_q) begin
            cmd_slot.valid = (launched < CNT_W'(2));
            cmd_slot.ch    = one_ch;
        end else begin
            cmd_slot.valid = pk_found;
            cmd_slot.ch    = pk_idx;
        end
        tx_word = cmd_slot.valid ? build_cmd(cmd_slot.ch, rng_q) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SEQ_IDLE;
            pend      <= '0;
            rng_q     <= 1'b0;
            one_q     <= 1'b0;
            one_ch    <= '0;
            total     <= '0;
            launched  <= '0;
            finished  <= '0;
            cur       <= '0;
            hist0     <= '0;
            hist1     <= '0;
            done      <= 1'b0;
            res_valid <= 1'b0;
            res_err   <= 1'b0;
            res_ch    <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            done      <= 1'b0;
            case (st)
                SEQ_IDLE: begin
                    if (start_ok) begin
                        st       <= SEQ_RUN;
                        pend     <= ch_en;
                        rng_q    <= range_dbl;
                        one_q    <= single_mode;
                        one_ch   <= single_ch;
                        total    <= single_mode ? CNT_W'(3)
                                                : CNT_W'(count_ones(en_wide) + 5'd2);
                        launched <= '0;
                        finished <= '0;
                        cur      <= '0;
                        hist0    <= '0;
                        hist1    <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (go) begin
                        launched <= launched + CNT_W'(1);
                        cur      <= cmd_slot;
                        if (!one_q && pk_found) begin
                            pend <= pend & ~(NUM_CH'(1) << pk_idx);
                        end
                    end
                    if (frame_done) begin
                        hist0    <= cur;
                        hist1    <= hist0;
                        finished <= finished + CNT_W'(1);
                        if (hist1.valid) begin
                            res_valid <= 1'b1;
                            res_ch    <= hist1.ch;
                            res_data  <= up_sample;
                            res_err   <= up_bad;
                        end
                        if (finished == total - CNT_W'(1)) begin
                            st   <= SEQ_IDLE;
                            done <= 1'b1;
                        end
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int NUM_CH = 16,
    parameter int DIV    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              single_mode,
    input logic [NUM_CH-1:0] ch_en,
    input logic              cs_n,
    input logic              sclk,
    input logic              mosi,
    input logic              busy,
    input logic              done,
    input logic              res_valid
);
    localparam int unsigned GAP_MIN = 2 * DIV;

    int unsigned hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= GAP_MIN;
        end else if (cs_n) begin
            hi_cnt <= (hi_cnt < GAP_MIN) ? hi_cnt + 1 : hi_cnt;
        end else begin
            hi_cnt <= 0;
        end
    end

    // R3
    gap_min_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (hi_cnt >= GAP_MIN));

    // R2
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R5
    frame_in_op_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> busy);

    // R11
    done_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (res_valid && !busy));

    // R6
    res_in_op_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !done) |-> busy);

    // R12
    empty_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !single_mode && (ch_en == '0)) |=> !busy);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NUM_CH(NUM_CH), .DIV(DIV)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .single_mode (single_mode),
    .ch_en       (ch_en),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .mosi        (mosi),
    .busy        (busy),
    .done        (done),
    .res_valid   (res_valid)
);

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;
    localparam int NCH = 16;
    localparam int RES = 10;
    localparam int DIV = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic           start = 1'b0;
    logic           single_mode = 1'b0;
    logic [3:0]     single_ch = '0;
    logic [NCH-1:0] ch_en = '0;
    logic           range_dbl = 1'b0;
    logic           miso;
    logic           sclk, cs_n, mosi, busy, done, res_valid, res_err;
    logic [3:0]     res_ch;
    logic [RES-1:0] res_data;

    adc_scan_seq #(.NUM_CH(NCH), .RES_BITS(RES), .DIV(DIV)) uut (
        .clk(clk), .rst(rst), .start(start), .single_mode(single_mode),
        .single_ch(single_ch), .ch_en(ch_en), .range_dbl(range_dbl),
        .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy),
        .done(done), .res_valid(res_valid), .res_err(res_err),
        .res_ch(res_ch), .res_data(res_data)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // converter model: answers the command from two frames earlier
    logic [11:0] samp [16];
    logic [15:0] out_sr = 16'hFFFF;
    logic [15:0] in_sr = '0;
    logic [15:0] h0 = '0;
    logic [15:0] h1 = '0;
    int          bitn = 0;
    bit          in_frame = 0;
    bit          seen_frame = 0;
    realtime     t_hi = 0;
    bit          bad_tag_en = 0;
    logic [3:0]  bad_tag_ch = '0;
    logic [15:0] cmd_log [32];
    int          ncmd = 0;
    int          frame_len_bad = 0;
    int          gap_bad = 0;

    assign miso = out_sr[15];

    function automatic logic [15:0] answer(logic [15:0] c);
        logic [3:0] ch;
        ch = c[10:7];
        if (c[12] && c[11])
            return {(bad_tag_en && ch == bad_tag_ch) ? (ch ^ 4'h5) : ch, samp[ch]};
        return 16'hFFFF;
    endfunction

    always @(negedge cs_n) begin
        if (seen_frame && ($realtime - t_hi) < (2 * DIV * 5.0)) gap_bad++;
        out_sr   = answer(h1);
        bitn     = 0;
        in_frame = 1;
    end
    always @(posedge sclk) if (cs_n === 1'b0) begin
        in_sr = {in_sr[14:0], mosi};
        bitn++;
    end
    always @(negedge sclk) if (cs_n === 1'b0) out_sr = {out_sr[14:0], 1'b1};
    always @(posedge cs_n) if (in_frame) begin
        in_frame   = 0;
        seen_frame = 1;
        t_hi       = $realtime;
        if (bitn != 16) frame_len_bad++;
        if (ncmd < 32) cmd_log[ncmd] = in_sr;
        ncmd++;
        h1 = h0;
        h0 = in_sr;
    end

    // result monitor
    logic [3:0]     r_ch  [32];
    logic [RES-1:0] r_dat [32];
    logic           r_err [32];
    int nres = 0;
    int ndone = 0;
    int done_alone = 0;

    always @(negedge clk) if (!rst) begin
        if (res_valid) begin
            if (nres < 32) begin
                r_ch[nres]  = res_ch;
                r_dat[nres] = res_data;
                r_err[nres] = res_err;
            end
            nres++;
        end
        if (done) begin
            ndone++;
            if (!res_valid) done_alone++;
        end
    end

    function automatic logic [15:0] exp_cmd(logic [3:0] ch, logic rng);
        return 16'h1800 | (16'(ch) << 7) | (16'(rng) << 6);
    endfunction

    task automatic clear_logs();
        ncmd = 0; nres = 0; ndone = 0; done_alone = 0;
        frame_len_bad = 0; gap_bad = 0;
    endtask

    task automatic run_op(input bit one, input logic [3:0] sch, input logic [15:0] mask,
                          input bit rng, input bit poke);
        logic [3:0]  exp_ch  [16];
        logic [15:0] exp_cw  [20];
        int          k = 0;
        int          nfr;
        int          cyc = 0;
        string       fr_req;
        clear_logs();
        for (int i = 0; i < 16; i++) samp[i] = 12'($urandom);
        if (one) begin
            exp_ch[0] = sch; k = 1;
            exp_cw[0] = exp_cmd(sch, rng); exp_cw[1] = exp_cmd(sch, rng); exp_cw[2] = '0;
            nfr = 3; fr_req = "R9";
        end else begin
            for (int c = 0; c < 16; c++) if (mask[c]) begin
                exp_ch[k] = 4'(c); exp_cw[k] = exp_cmd(4'(c), rng); k++;
            end
            exp_cw[k] = '0; exp_cw[k+1] = '0;
            nfr = k + 2; fr_req = "R5";
        end
        @(negedge clk);
        single_mode = one; single_ch = sch; ch_en = mask; range_dbl = rng; start = 1;
        @(negedge clk);
        start = 0;
        ch_en = 16'($urandom); range_dbl = ~rng; single_ch = sch + 4'd1;
        while (ndone == 0 && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 300) begin
                start = 1; single_mode = ~one; ch_en = 16'h0003;
            end else start = 0;
        end
        start = 0;
        repeat (12) @(negedge clk);
        // R11 one done, with the last result, busy released
        check(ndone == 1, "R11 done count", ndone, 1);
        check(done_alone == 0, "R11 done without result", done_alone, 0);
        check(busy == 0, "R11 busy after done", busy, 0);
        check(ncmd == nfr, {fr_req, " frame count"}, ncmd, nfr);
        for (int i = 0; i < nfr && i < ncmd && i < 32; i++)
            check(cmd_log[i] == exp_cw[i], {fr_req, " R4 command word"}, cmd_log[i], exp_cw[i]);
        check(nres == k, "R6 result count", nres, k);
        for (int i = 0; i < k && i < nres; i++) begin
            logic [RES-1:0] ed;
            logic           ee;
            ed = RES'(samp[exp_ch[i]] >> (12 - RES));
            ee = bad_tag_en && (exp_ch[i] == bad_tag_ch);
            check(r_ch[i] == exp_ch[i], "R6 result channel", r_ch[i], exp_ch[i]);
            check(r_dat[i] == ed, "R7 sample field", r_dat[i], ed);
            check(r_err[i] == ee, "R8 tag error flag", r_err[i], ee);
        end
        check(frame_len_bad == 0, "R2 frame length", frame_len_bad, 0);
        check(gap_bad == 0, "R3 chip-select gap", gap_bad, 0);
    endtask

    initial begin
        #750000;
        errors++; checks++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (5) @(negedge clk);
        // R1 during reset
        check(cs_n == 1 && sclk == 0 && mosi == 0, "R1 link idle in reset", {cs_n, sclk, mosi}, 3'b100);
        check(busy == 0 && done == 0 && res_valid == 0, "R1 status in reset", {busy, done, res_valid}, 0);
        rst = 0;
        @(negedge clk);
        check(cs_n == 1 && sclk == 0 && busy == 0 && res_valid == 0 && done == 0,
              "R1 state after reset", {cs_n, sclk, busy, res_valid, done}, 5'b10000);

        // directed scans
        run_op(0, 4'd0, 16'h0001, 1'b1, 0);
        run_op(0, 4'd0, 16'hFFFF, 1'b0, 0);
        run_op(0, 4'd0, 16'h8001, 1'b1, 0);
        // single reads at both ends
        run_op(1, 4'd0, 16'h0000, 1'b0, 0);
        run_op(1, 4'd15, 16'h0000, 1'b1, 0);
        // R8 tag corruption on one channel
        bad_tag_en = 1; bad_tag_ch = 4'd3;
        run_op(0, 4'd0, 16'h00F8, 1'b0, 0);
        bad_tag_ch = 4'd9;
        run_op(1, 4'd9, 16'h0000, 1'b1, 0);
        bad_tag_en = 0;
        // R10 start while busy
        run_op(0, 4'd0, 16'hFFFF, 1'b1, 1);

        // R12 empty mask
        clear_logs();
        @(negedge clk);
        single_mode = 0; ch_en = '0; start = 1;
        @(negedge clk);
        start = 0;
        begin
            int busy_seen = 0;
            for (int i = 0; i < 80; i++) begin
                @(negedge clk);
                if (busy) busy_seen++;
            end
            check(busy_seen == 0, "R12 busy on empty mask", busy_seen, 0);
        end
        check(ncmd == 0, "R12 frames on empty mask", ncmd, 0);
        check(ndone == 0, "R12 done on empty mask", ndone, 0);

        // random scans and reads
        for (int n = 0; n < 6; n++) begin
            logic [15:0] m;
            m = 16'($urandom);
            if (m == 0) m = 16'h0100;
            run_op(0, 4'd0, m, 1'($urandom), 0);
        end
        for (int n = 0; n < 3; n++) run_op(1, 4'($urandom), 16'h0, 1'($urandom), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule